// File: doc/BRIEF.md
# Guarded Byte-Store Write Controller

This block sits between a small processor bus and a byte-wide non-volatile data store that lives outside the normal data address space. Software reaches the store through four bus registers: a cell address, a data byte, a control word and a write-only key register. A read is a single bus write to the control word. The addressed byte lands in the data register at the same clock edge, so the next bus access can pick it up.

Programming a cell is slow and guarded. Software must already have the enable bit set. It must then write the two key bytes 0x55 and 0xAA in that order, and only then set the write bit. If any of these steps is missing, the write request is dropped silently. An accepted write captures the address and data, holds the write bit high for a parameterised number of cycles, commits the byte, and then raises a completion flag. The flag stays set until software clears it.

Top module: `eeprom_guard`

## Requirements
- R1: After reset the address, data and control registers read 0x00, and the key sequence is back at its start.
- R2: Bus register select 0 is the cell address (AW bits, upper bits read 0), select 1 is the data byte, select 2 is the control word, and select 3 is the key register, which always reads 0x00. Writes to selects 0 and 1 read back.
- R3: Writing 1 to control bit 0 (read) copies the byte at the current address into the data register at that edge. Bit 0 then reads 1 for exactly one cycle. A read request made while programming is in progress is ignored.
- R4: A write request (control bit 1 written as 1) is accepted only if control bit 2 (enable) was already 1 from an earlier control write and the key sequence is complete. Otherwise bit 1 stays 0 and the store is unchanged.
- R5: The key sequence advances only on a key write of 0x55 followed by a key write of 0xAA. Any other key byte, including a repeated 0x55, returns it to its start.
- R6: An accepted write holds control bit 1 at 1 for PROG_CYCLES cycles. It then stores the captured byte at the captured address, clears bit 1 and sets control bit 3 (done).
- R7: Software cannot clear control bit 1 while programming is in progress.
- R8: Control bit 3 is cleared only by a control write with bit 3 at 0. Writing it as 1 has no effect. The hardware set wins over a clear made in the same cycle.
- R9: An accepted write consumes the key sequence, so a further write request needs a fresh 0x55, 0xAA pair.
- R10: Changing the address or data register during programming does not alter which cell is programmed or the value it receives.
- R11: mem_rd_stb is high for the one cycle in which a read request is accepted. mem_wr_stb is high for the one cycle in which the captured byte is committed to the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Bus write strobe, one register write per cycle |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Read data of the selected register |
| mem_rd_stb | output | 1 | Store read strobe |
| mem_wr_stb | output | 1 | Store commit strobe |

## Verification
The assertions assume that bus_sel and bus_wdata carry meaning only in cycles where bus_wr is high. They also assume at most one register is written per cycle, so a key write and a control write never fall on the same edge. The bench respects this by changing all bus inputs on the falling edge and returning bus_wr to 0 after each single-cycle write. The bench uses a short programming time so that the whole busy window can be checked cycle by cycle. This includes the commit strobe in the final busy cycle and the attempts made during the window to clear the write bit, start a read, or rewrite the address and data.

// File: rtl/eeprom_guard.sv
module eeprom_guard #(
  parameter int AW          = 6,
  parameter int PROG_CYCLES = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       mem_rd_stb,
  output logic       mem_wr_stb
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(PROG_CYCLES + 1);
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_KEY  = 2'd3;
  localparam logic [7:0] KEY_A = 8'h55;
  localparam logic [7:0] KEY_B = 8'hAA;

  logic [7:0]    cells [DEPTH];
  logic [AW-1:0] addr_q, paddr_q;
  logic [7:0]    data_q, pdata_q;
  logic          rd_q, wr_q, wren_q, done_q;
  logic [1:0]    ul_q;
  logic [CW-1:0] cnt_q;

  wire ctrl_w = bus_wr && (bus_sel == SEL_CTRL);
  wire key_w  = bus_wr && (bus_sel == SEL_KEY);
  wire rd_go  = ctrl_w && bus_wdata[0] && !wr_q;
  wire wr_go  = ctrl_w && bus_wdata[1] && wren_q && (ul_q == 2'd2) && !wr_q;
  wire finish = wr_q && (cnt_q == CW'(1));

  assign mem_rd_stb = rd_go;
  assign mem_wr_stb = finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (bus_wr && bus_sel == SEL_ADDR) addr_q <= bus_wdata[AW-1:0];
      if (rd_go) data_q <= cells[addr_q];
      else if (bus_wr && bus_sel == SEL_DATA) data_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      wren_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rd_q <= rd_go;
      if (ctrl_w) wren_q <= bus_wdata[2];
      if (finish) done_q <= 1'b1;
      else if (ctrl_w && !bus_wdata[3]) done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ul_q <= 2'd0;
    end else if (key_w) begin
      case (ul_q)
        2'd0:    ul_q <= (bus_wdata == KEY_A) ? 2'd1 : 2'd0;
        2'd1:    ul_q <= (bus_wdata == KEY_B) ? 2'd2 : 2'd0;
        default: ul_q <= 2'd0;
      endcase
    end else if (wr_go) begin
      ul_q <= 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      cnt_q   <= '0;
      paddr_q <= '0;
      pdata_q <= '0;
    end else if (wr_go) begin
      wr_q    <= 1'b1;
      cnt_q   <= CW'(PROG_CYCLES);
      paddr_q <= addr_q;
      pdata_q <= data_q;
    end else if (wr_q) begin
      cnt_q <= cnt_q - CW'(1);
      if (finish) wr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (finish) cells[paddr_q] <= pdata_q;
  end

  always_comb begin
    case (bus_sel)
      SEL_ADDR: bus_rdata = {{(8-AW){1'b0}}, addr_q};
      SEL_DATA: bus_rdata = data_q;
      SEL_CTRL: bus_rdata = {4'b0, done_q, wren_q, wr_q, rd_q};
      default:  bus_rdata = 8'h00;
    endcase
  end
endmodule

module eeprom_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [1:0] bus_sel,
  input logic [7:0] bus_wdata,
  input logic       rd_q,
  input logic       wr_q,
  input logic       wren_q,
  input logic       done_q,
  input logic [1:0] ul_q,
  input logic       mem_rd_stb,
  input logic       mem_wr_stb
);
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd2 && !(wren_q && ul_q == 2'd2) && !wr_q) |=> !wr_q); // R4
  AST_KEY_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_q) |-> ul_q == 2'd0); // R9
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !mem_wr_stb) |=> wr_q); // R7
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_stb |=> (done_q && !wr_q)); // R6
  AST_DONE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(bus_wr && bus_sel == 2'd2 && !bus_wdata[3])) |=> done_q); // R8
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |=> !rd_q); // R3
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_stb |-> !wr_q); // R3
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_stb |-> wr_q); // R11
endmodule

bind eeprom_guard eeprom_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
  .rd_q(rd_q), .wr_q(wr_q), .wren_q(wren_q), .done_q(done_q), .ul_q(ul_q),
  .mem_rd_stb(mem_rd_stb), .mem_wr_stb(mem_wr_stb)
);

// File: tb/eeprom_guard_bench.sv
module eeprom_guard_bench;
  localparam int CLK_P = 10;
  localparam int PROG  = 20;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic mem_rd_stb, mem_wr_stb;
  logic seen_rd, seen_wr;
  int total = 0, bad = 0;

  eeprom_guard #(.AW(6), .PROG_CYCLES(PROG)) u_eeprom_guard (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_rd_stb(mem_rd_stb), .mem_wr_stb(mem_wr_stb)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bwrite(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = s; bus_wdata = v;
    #1 seen_rd = mem_rd_stb; seen_wr = mem_wr_stb;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [1:0] s, output logic [7:0] v);
    bus_sel = s;
    #1 v = bus_rdata;
  endtask

  task automatic unlock();
    bwrite(2'd3, 8'h55);
    bwrite(2'd3, 8'hAA);
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    for (int i = 0; i < PROG + 5; i++) begin
      bread(2'd2, c);
      if (!c[1]) break;
      @(negedge clk);
    end
  endtask

  task automatic read_cell(input logic [5:0] a, output logic [7:0] v);
    bwrite(2'd0, {2'b00, a});
    bwrite(2'd2, 8'h01);
    bread(2'd1, v);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    bread(2'd0, v); check("R1 addr", v, 8'h00);
    bread(2'd1, v); check("R1 data", v, 8'h00);
    bread(2'd2, v); check("R1 ctrl", v, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    bwrite(2'd0, 8'hFF); bread(2'd0, v); check("R2 addr width", v, 8'h3F);
    bwrite(2'd1, 8'hA5); bread(2'd1, v); check("R2 data", v, 8'hA5);
    bwrite(2'd3, 8'h12); bread(2'd3, v); check("R2 key reads 0", v, 8'h00);
  endtask

  task automatic t_write_ok();
    logic [7:0] v;
    bwrite(2'd0, 8'h05); bwrite(2'd1, 8'h3C); bwrite(2'd2, 8'h04);
    unlock();
    bwrite(2'd2, 8'h06);
    for (int i = 0; i < PROG; i++) begin
      bread(2'd2, v);
      check("R6 busy bit", {7'b0, v[1]}, 8'h01);
      check("R11 wr strobe", {7'b0, mem_wr_stb}, {7'b0, i == PROG - 1});
      @(negedge clk);
    end
    bread(2'd2, v);
    check("R6 done set, busy clear", v & 8'h0A, 8'h08);
    read_cell(6'd5, v);
    check("R6 stored byte", v, 8'h3C);
    check("R11 rd strobe", {7'b0, seen_rd}, 8'h01);
  endtask

  task automatic t_read();
    logic [7:0] v;
    bwrite(2'd0, 8'h05); bwrite(2'd1, 8'h00);
    bwrite(2'd2, 8'h01);
    bread(2'd2, v); check("R3 rd bit high", {7'b0, v[0]}, 8'h01);
    bread(2'd1, v); check("R3 data loaded", v, 8'h3C);
    @(negedge clk);
    bread(2'd2, v); check("R3 rd bit self-clears", {7'b0, v[0]}, 8'h00);
  endtask

  task automatic t_no_wren();
    logic [7:0] v;
    bwrite(2'd2, 8'h00);
    unlock();
    bwrite(2'd2, 8'h06);
    bread(2'd2, v); check("R4 enable set in same write ignored", {7'b0, v[1]}, 8'h00);
    bwrite(2'd2, 8'h06);
    bread(2'd2, v); check("R4 accepted once enable held", {7'b0, v[1]}, 8'h01);
    wait_idle();
  endtask

  task automatic t_bad_key();
    logic [7:0] v;
    bwrite(2'd0, 8'h09); bwrite(2'd1, 8'h77); bwrite(2'd2, 8'h04);
    bwrite(2'd3, 8'h55); bwrite(2'd3, 8'h12); bwrite(2'd3, 8'hAA);
    bwrite(2'd2, 8'h06);
    bread(2'd2, v); check("R5 stray key byte", {7'b0, v[1]}, 8'h00);
    bwrite(2'd3, 8'h55); bwrite(2'd3, 8'h55); bwrite(2'd3, 8'hAA);
    bwrite(2'd2, 8'h06);
    bread(2'd2, v); check("R5 repeated 0x55", {7'b0, v[1]}, 8'h00);
    unlock();
    bwrite(2'd2, 8'h06);
    bread(2'd2, v); check("R5 clean sequence", {7'b0, v[1]}, 8'h01);
    wait_idle();
    read_cell(6'd9, v); check("R5 stored", v, 8'h77);
  endtask

  task automatic t_busy();
    logic [7:0] v;
    bwrite(2'd0, 8'h0A); bwrite(2'd1, 8'h5A); bwrite(2'd2, 8'h04);
    unlock();
    bwrite(2'd2, 8'h06);
    bwrite(2'd2, 8'h04);
    bread(2'd2, v); check("R7 busy bit not clearable", {7'b0, v[1]}, 8'h01);
    bwrite(2'd0, 8'h05); bwrite(2'd1, 8'hEE);
    bwrite(2'd2, 8'h05);
    check("R3 no rd strobe while busy", {7'b0, seen_rd}, 8'h00);
    bread(2'd1, v); check("R3 read ignored while busy", v, 8'hEE);
    wait_idle();
    read_cell(6'd10, v); check("R10 captured cell and byte", v, 8'h5A);
    read_cell(6'd5, v); check("R10 other cell untouched", v, 8'h3C);
  endtask

  task automatic t_done_clear();
    logic [7:0] v;
    bwrite(2'd0, 8'h0B); bwrite(2'd1, 8'h11); bwrite(2'd2, 8'h04);
    unlock(); bwrite(2'd2, 8'h06);
    wait_idle();
    bwrite(2'd2, 8'h0C);
    bread(2'd2, v); check("R8 write 1 keeps done", {7'b0, v[3]}, 8'h01);
    bwrite(2'd2, 8'h04);
    bread(2'd2, v); check("R8 write 0 clears done", {7'b0, v[3]}, 8'h00);
  endtask

  task automatic t_reuse();
    logic [7:0] v;
    bwrite(2'd1, 8'h99);
    bwrite(2'd2, 8'h06);
    bread(2'd2, v); check("R9 key consumed", {7'b0, v[1]}, 8'h00);
    repeat (PROG + 2) @(negedge clk);
    read_cell(6'd11, v); check("R9 cell unchanged", v, 8'h11);
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_write_ok();
    t_read();
    t_no_wren();
    t_bad_key();
    t_busy();
    t_done_clear();
    t_reuse();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule